// File: doc/BRIEF.md
# Index-Addressed Real-Time Clock Register File

This block keeps calendar time and makes it readable through two byte ports. An index port holds the number of the register to read. A later strobe on the data port returns that register's byte, one cycle afterwards. The time registers count in plain binary with a 24-hour day. They are seconds, minutes, hours, weekday, day of month, month and year, where the year is held as an offset from 1952. The time advances once per second, and a cycle divider set by a parameter makes that second. The power-up time comes from parameters. The defaults give Sunday 1 January 2006, 00:00:00.

Three control indices return fixed bytes. The first of them also carries an update-in-progress flag. This flag rises a set number of cycles before each second's update. A second divider runs a periodic interrupt at the 1024 Hz rate. Each of its ticks sets a level interrupt latch, and the latch holds until software acknowledges it. A write to the data port is treated as an access error. So is a read of an unsupported index. Either one raises a one-cycle error pulse.

Top module: `rtc_index_regs`

## Requirements
- R1: A cycle with `idx_wr` high stores `wdata` as the register index, and every later `data_rd` reads from that index. Reset clears the index to 0x00. When `idx_wr` and `data_rd` fall in the same cycle, the read uses the index held before that cycle.
- R2: Index 0x0B reads 0x46 and index 0x0C reads 0x00. Index 0x0A reads 0x26 in bits 6:0.
- R3: Binary time reads are at these indices: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06 (0–6, Sunday 0), day of month 0x07, month 0x08 (1–12) and year 0x09 (calendar year minus 1952). After reset these hold the parameter start time. With the default parameters they read 0, 0, 0, 0, 1, 1, 54.
- R4: The time advances by exactly one second every `SEC_CYCLES` clocks counted from reset release. Seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, and hours wrap 23→0 into the next day.
- R5: On a day change the weekday goes 6→0, otherwise +1. Past the last day of the month the day returns to 1 and the month advances, and after month 12 the month returns to 1 and the year offset increments. February has 29 days when the year offset is divisible by 4, otherwise 28. April, June, September and November have 30 days, and the other months have 31.
- R6: Bit 7 of the byte read at index 0x0A is 1 exactly when the read falls in one of the last `UIP_CYCLES` clock cycles before a seconds update.
- R7: Every `PER_CYCLES` clocks a periodic tick sets `irq`. `irq` stays high until it is acknowledged and stays low until the next tick.
- R8: `irq_ack` clears `irq` on the next cycle. If a periodic tick falls in the same cycle as the acknowledge, the tick wins and `irq` stays high.
- R9: A `data_wr` cycle makes `acc_err` pulse high on the next cycle. It changes no register that can be read back.
- R10: A `data_rd` of index 0x0D, or of any index not named in R2 or R3, makes `acc_err` pulse high on the next cycle and loads 0x00 into `rdata`.
- R11: `rdata` is loaded on the clock edge that samples `data_rd` high and holds its value in every other cycle. It is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Store `wdata` as register index |
| data_rd | input | 1 | Read the indexed register into `rdata` |
| data_wr | input | 1 | Data-port write (unsupported, flags error) |
| wdata | input | 8 | Write byte for index port and data port |
| irq_ack | input | 1 | Acknowledge and clear periodic interrupt |
| rdata | output | 8 | Registered read byte |
| acc_err | output | 1 | One-cycle access-error pulse |
| irq | output | 1 | Latched periodic interrupt level |

## Verification
Two pairs of events can land in the same cycle, and both are checked. In the first pair, a periodic tick meets an acknowledge. The bench tracks the divider phase in its own model and raises `irq_ack` exactly in a tick cycle, where `irq` must stay high. It also raises `irq_ack` in a quiet cycle, where `irq` must drop. In the second pair, a read meets the seconds update. The bench reads index 0x0A inside the update-in-progress window, where bit 7 must be set. Random reads landing in the update cycle itself must return the pre-update time. Four start times place the day, month, leap-February and year rollovers within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  localparam logic [7:0] IX_SEC  = 8'h00;
  localparam logic [7:0] IX_MIN  = 8'h02;
  localparam logic [7:0] IX_HOUR = 8'h04;
  localparam logic [7:0] IX_DOW  = 8'h06;
  localparam logic [7:0] IX_DOM  = 8'h07;
  localparam logic [7:0] IX_MON  = 8'h08;
  localparam logic [7:0] IX_YEAR = 8'h09;
  localparam logic [7:0] IX_CTLA = 8'h0A;
  localparam logic [7:0] IX_CTLB = 8'h0B;
  localparam logic [7:0] IX_CTLC = 8'h0C;

  localparam logic [6:0] CTLA_LOW = 7'h26;
  localparam logic [7:0] CTLB_VAL = 8'h46;
  localparam logic [7:0] CTLC_VAL = 8'h00;

  // days in a month; the 1952 base is a leap year, so offset%4 decides
  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [7:0] yr_ofs);
    case (mon)
      4'd2:                   month_len = (yr_ofs[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      default:                month_len = 5'd31;
    endcase
  endfunction

  // one-second step of the whole calendar
  function automatic rtc_time_t advance_second(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 6'd59) begin
      n.sec = t.sec + 6'd1;
    end else begin
      n.sec = 6'd0;
      if (t.min != 6'd59) begin
        n.min = t.min + 6'd1;
      end else begin
        n.min = 6'd0;
        if (t.hour != 5'd23) begin
          n.hour = t.hour + 5'd1;
        end else begin
          n.hour = 5'd0;
          n.dow  = (t.dow == 3'd6) ? 3'd0 : t.dow + 3'd1;
          if (t.dom != month_len(t.mon, t.yr)) begin
            n.dom = t.dom + 5'd1;
          end else begin
            n.dom = 5'd1;
            if (t.mon != 4'd12) begin
              n.mon = t.mon + 4'd1;
            end else begin
              n.mon = 4'd1;
              n.yr  = t.yr + 8'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] ctla_byte(input logic uip);
    return {uip, CTLA_LOW};
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int SEC_CYCLES    = 125_000_000,
  parameter int UIP_CYCLES    = 30_500,
  parameter int INIT_SEC      = 0,
  parameter int INIT_MIN      = 0,
  parameter int INIT_HOUR     = 0,
  parameter int INIT_DOW      = 0,
  parameter int INIT_DOM      = 1,
  parameter int INIT_MON      = 1,
  parameter int INIT_YEAR_OFS = 54
) (
  input  logic      clk,
  input  logic      rst_n,
  output rtc_time_t now,
  output logic      uip
);

  localparam int SW = (SEC_CYCLES > 1) ? $clog2(SEC_CYCLES) : 1;
  localparam logic [SW-1:0] SLAST    = SW'(SEC_CYCLES - 1);
  localparam logic [SW-1:0] UIP_FROM = SW'(SEC_CYCLES - UIP_CYCLES);
  localparam rtc_time_t INIT_TIME = rtc_time_t'({8'(INIT_YEAR_OFS), 4'(INIT_MON), 5'(INIT_DOM),
                                                 3'(INIT_DOW), 5'(INIT_HOUR), 6'(INIT_MIN),
                                                 6'(INIT_SEC)});

  logic [SW-1:0] scnt;
  logic          sec_tick;

  assign sec_tick = (scnt == SLAST);
  assign uip      = (scnt >= UIP_FROM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt <= '0;
      now  <= INIT_TIME;
    end else begin
      scnt <= sec_tick ? '0 : scnt + 1'b1;
      if (sec_tick) now <= advance_second(now);
    end
  end

  assert_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(now)) else $error("time changed without a second tick");

  assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && now.sec != 6'd59) |=> (now.sec == $past(now.sec) + 6'd1))
    else $error("seconds did not step by one");

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && now.sec == 6'd59) |=> (now.sec == 6'd0 && now.min != $past(now.min)))
    else $error("seconds wrap did not carry");

  assert_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (now.mon >= 4'd1 && now.mon <= 4'd12 && now.dom >= 5'd1 && now.dow <= 3'd6))
    else $error("calendar field out of range");

  assert_uip_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(sec_tick)) else $error("update flag dropped without an update");

endmodule

// File: rtl/rtc_irq_latch.sv
module rtc_irq_latch #(
  parameter int PER_CYCLES = 122_070
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_ack,
  output logic irq
);

  localparam int PW = (PER_CYCLES > 1) ? $clog2(PER_CYCLES) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PER_CYCLES - 1);

  logic [PW-1:0] pcnt;
  logic          per_tick;

  assign per_tick = (pcnt == PLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      irq  <= 1'b0;
    end else begin
      pcnt <= per_tick ? '0 : pcnt + 1'b1;
      if (per_tick)     irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> irq) else $error("tick did not raise irq");

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq) else $error("irq dropped without ack");

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !per_tick) |=> !irq) else $error("irq rose without tick");

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !per_tick) |=> !irq) else $error("ack did not clear irq");

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
(
  input  logic [7:0] idx,
  input  rtc_time_t  now,
  input  logic       uip,
  output logic [7:0] rd_byte,
  output logic       rd_bad
);

  always_comb begin
    rd_bad  = 1'b0;
    rd_byte = 8'h00;
    case (idx)
      IX_SEC:  rd_byte = {2'b00, now.sec};
      IX_MIN:  rd_byte = {2'b00, now.min};
      IX_HOUR: rd_byte = {3'b000, now.hour};
      IX_DOW:  rd_byte = {5'b00000, now.dow};
      IX_DOM:  rd_byte = {3'b000, now.dom};
      IX_MON:  rd_byte = {4'b0000, now.mon};
      IX_YEAR: rd_byte = now.yr;
      IX_CTLA: rd_byte = ctla_byte(uip);
      IX_CTLB: rd_byte = CTLB_VAL;
      IX_CTLC: rd_byte = CTLC_VAL;
      default: rd_bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_pkg::*;
#(
  parameter int SEC_CYCLES    = 125_000_000,
  parameter int UIP_CYCLES    = 30_500,
  parameter int PER_CYCLES    = 122_070,
  parameter int INIT_SEC      = 0,
  parameter int INIT_MIN      = 0,
  parameter int INIT_HOUR     = 0,
  parameter int INIT_DOW      = 0,
  parameter int INIT_DOM      = 1,
  parameter int INIT_MON      = 1,
  parameter int INIT_YEAR_OFS = 54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic       irq_ack,
  output logic [7:0] rdata,
  output logic       acc_err,
  output logic       irq
);

  rtc_time_t  now;
  logic       uip;
  logic [7:0] idx_q;
  logic [7:0] sel_byte;
  logic       sel_bad;

  rtc_calendar #(
    .SEC_CYCLES(SEC_CYCLES), .UIP_CYCLES(UIP_CYCLES),
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_DOW(INIT_DOW), .INIT_DOM(INIT_DOM), .INIT_MON(INIT_MON),
    .INIT_YEAR_OFS(INIT_YEAR_OFS)
  ) u_cal (
    .clk(clk), .rst_n(rst_n), .now(now), .uip(uip)
  );

  rtc_irq_latch #(.PER_CYCLES(PER_CYCLES)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq(irq)
  );

  rtc_read_mux u_mux (
    .idx(idx_q), .now(now), .uip(uip), .rd_byte(sel_byte), .rd_bad(sel_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      rdata   <= 8'h00;
      acc_err <= 1'b0;
    end else begin
      if (idx_wr)  idx_q <= wdata;
      if (data_rd) rdata <= sel_byte;
      acc_err <= data_wr | (data_rd & sel_bad);
    end
  end

  assert_wr_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> acc_err) else $error("data write not flagged");

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(data_wr || data_rd)) else $error("error without an access");

  assert_bad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && sel_bad) |=> (rdata == 8'h00 && acc_err)) else $error("bad read not zero");

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(rdata)) else $error("rdata changed without read");

endmodule

// File: tb/rtc_index_regs_tb.sv
module rtc_index_regs_tb;
  localparam int SEC_C = 50;
  localparam int PER_C = 7;
  localparam int UIP_C = 3;
  localparam int NI    = 4;

  // start times: defaults, leap Feb 28, common Feb 28, Dec 31
  localparam int S_SEC [NI] = '{0, 58, 58, 58};
  localparam int S_MIN [NI] = '{0, 59, 59, 59};
  localparam int S_HOUR[NI] = '{0, 23, 23, 23};
  localparam int S_DOW [NI] = '{0, 4, 3, 1};
  localparam int S_DOM [NI] = '{1, 28, 28, 31};
  localparam int S_MON [NI] = '{1, 2, 2, 12};
  localparam int S_YR  [NI] = '{54, 56, 55, 55};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       idx_wr = 0, data_rd = 0, data_wr = 0, irq_ack = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_o [NI];
  logic       err_o[NI];
  logic       irq_o[NI];

  rtc_index_regs #(.SEC_CYCLES(SEC_C), .UIP_CYCLES(UIP_C), .PER_CYCLES(PER_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_rd(data_rd), .data_wr(data_wr),
    .wdata(wdata), .irq_ack(irq_ack), .rdata(rd_o[0]), .acc_err(err_o[0]), .irq(irq_o[0]));

  rtc_index_regs #(.SEC_CYCLES(SEC_C), .UIP_CYCLES(UIP_C), .PER_CYCLES(PER_C),
    .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(4), .INIT_DOM(28),
    .INIT_MON(2), .INIT_YEAR_OFS(56)) u_dut_leap (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_rd(data_rd), .data_wr(data_wr),
    .wdata(wdata), .irq_ack(irq_ack), .rdata(rd_o[1]), .acc_err(err_o[1]), .irq(irq_o[1]));

  rtc_index_regs #(.SEC_CYCLES(SEC_C), .UIP_CYCLES(UIP_C), .PER_CYCLES(PER_C),
    .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(3), .INIT_DOM(28),
    .INIT_MON(2), .INIT_YEAR_OFS(55)) u_dut_common (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_rd(data_rd), .data_wr(data_wr),
    .wdata(wdata), .irq_ack(irq_ack), .rdata(rd_o[2]), .acc_err(err_o[2]), .irq(irq_o[2]));

  rtc_index_regs #(.SEC_CYCLES(SEC_C), .UIP_CYCLES(UIP_C), .PER_CYCLES(PER_C),
    .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(1), .INIT_DOM(31),
    .INIT_MON(12), .INIT_YEAR_OFS(55)) u_dut_year (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_rd(data_rd), .data_wr(data_wr),
    .wdata(wdata), .irq_ack(irq_ack), .rdata(rd_o[3]), .acc_err(err_o[3]), .irq(irq_o[3]));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int inst, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s inst %0d actual %0h expected %0h at %0t", tag, inst, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int t_sec[NI], t_min[NI], t_hour[NI], t_dow[NI], t_dom[NI], t_mon[NI], t_yr[NI];
  int m_idx[NI], m_rd[NI], m_err[NI], m_irq[NI];
  string m_tag[NI];
  int m_scnt, m_pcnt;

  function automatic int days_of(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic next_second(input int i);
    t_sec[i]++;
    if (t_sec[i] == 60) begin
      t_sec[i] = 0; t_min[i]++;
      if (t_min[i] == 60) begin
        t_min[i] = 0; t_hour[i]++;
        if (t_hour[i] == 24) begin
          t_hour[i] = 0;
          t_dow[i] = (t_dow[i] + 1) % 7;
          t_dom[i]++;
          if (t_dom[i] > days_of(t_mon[i], t_yr[i])) begin
            t_dom[i] = 1; t_mon[i]++;
            if (t_mon[i] == 13) begin
              t_mon[i] = 1; t_yr[i] = (t_yr[i] + 1) % 256;
            end
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scnt = 0; m_pcnt = 0;
      for (int i = 0; i < NI; i++) begin
        t_sec[i] = S_SEC[i]; t_min[i] = S_MIN[i]; t_hour[i] = S_HOUR[i]; t_dow[i] = S_DOW[i];
        t_dom[i] = S_DOM[i]; t_mon[i] = S_MON[i]; t_yr[i] = S_YR[i];
        m_idx[i] = 0; m_rd[i] = 0; m_err[i] = 0; m_irq[i] = 0; m_tag[i] = "R11";
      end
    end else begin
      bit in_uip;
      bit sec_edge;
      bit per_edge;
      in_uip   = (m_scnt >= SEC_C - UIP_C);
      sec_edge = (m_scnt == SEC_C - 1);
      per_edge = (m_pcnt == PER_C - 1);
      for (int i = 0; i < NI; i++) begin
        bit bad;
        bad = 0;
        if (data_rd) begin
          case (m_idx[i])
            0:  begin m_rd[i] = t_sec[i];  m_tag[i] = "R3/R4"; end
            2:  begin m_rd[i] = t_min[i];  m_tag[i] = "R3/R4"; end
            4:  begin m_rd[i] = t_hour[i]; m_tag[i] = "R3/R4"; end
            6:  begin m_rd[i] = t_dow[i];  m_tag[i] = "R3/R5"; end
            7:  begin m_rd[i] = t_dom[i];  m_tag[i] = "R3/R5"; end
            8:  begin m_rd[i] = t_mon[i];  m_tag[i] = "R3/R5"; end
            9:  begin m_rd[i] = t_yr[i];   m_tag[i] = "R3/R5"; end
            10: begin m_rd[i] = (in_uip ? 128 : 0) + 38; m_tag[i] = "R2/R6"; end
            11: begin m_rd[i] = 70; m_tag[i] = "R2"; end
            12: begin m_rd[i] = 0;  m_tag[i] = "R2"; end
            default: begin m_rd[i] = 0; bad = 1; m_tag[i] = "R10"; end
          endcase
        end
        m_err[i] = (data_wr || (data_rd && bad)) ? 1 : 0;
        if (idx_wr) m_idx[i] = int'(wdata);
        if (per_edge) m_irq[i] = 1;
        else if (irq_ack) m_irq[i] = 0;
        if (sec_edge) next_second(i);
      end
      m_scnt = sec_edge ? 0 : m_scnt + 1;
      m_pcnt = per_edge ? 0 : m_pcnt + 1;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NI; i++) begin
        chk(int'(rd_o[i]) == m_rd[i], {m_tag[i], "/R1/R11 rdata"}, i, int'(rd_o[i]), m_rd[i]);
        chk(int'(err_o[i]) == m_err[i], "R9/R10 acc_err", i, int'(err_o[i]), m_err[i]);
        chk(int'(irq_o[i]) == m_irq[i], "R7/R8 irq", i, int'(irq_o[i]), m_irq[i]);
      end
    end
  end

  task automatic read_at(input int ix);
    idx_wr = 1; wdata = 8'(ix);
    @(negedge clk);
    idx_wr = 0; data_rd = 1;
    @(negedge clk);
    data_rd = 0;
  endtask

  initial begin
    #(8 * 200_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset index is 0x00 (seconds)
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
    chk(rd_o[0] == 8'h00, "R1 reset index", 0, int'(rd_o[0]), 0);
    // R3/R2/R10: sweep all low indices on the start time
    for (int k = 0; k < 16; k++) read_at(k);
    read_at(8'h09);
    chk(rd_o[0] == 8'd54, "R3 default year", 0, int'(rd_o[0]), 54);
    // R9: data write is flagged and changes nothing
    data_wr = 1; wdata = 8'h33;
    @(negedge clk);
    data_wr = 0;
    chk(err_o[0] == 1'b1, "R9 write error", 0, int'(err_o[0]), 1);
    read_at(8'h09);
    chk(rd_o[0] == 8'd54, "R9 year untouched", 0, int'(rd_o[0]), 54);
    // R1: index write and read in one cycle use the old index (0x09)
    idx_wr = 1; data_rd = 1; wdata = 8'h0B;
    @(negedge clk);
    idx_wr = 0; data_rd = 0;
    chk(rd_o[0] == 8'd54, "R1 old index on same cycle", 0, int'(rd_o[0]), 54);
    // R6: read control A inside the update window
    idx_wr = 1; wdata = 8'h0A;
    @(negedge clk);
    idx_wr = 0;
    while (m_scnt != SEC_C - 2) @(negedge clk);
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
    chk(rd_o[0] == 8'hA6, "R6 uip set", 0, int'(rd_o[0]), 8'hA6);
    // R8: ack coinciding with a tick keeps irq
    for (int n = 0; n < 3; n++) begin
      while (!(m_pcnt == PER_C - 1 && m_irq[0] == 1)) @(negedge clk);
      irq_ack = 1;
      @(negedge clk);
      irq_ack = 0;
      chk(irq_o[0] == 1'b1, "R8 tick beats ack", 0, int'(irq_o[0]), 1);
    end
    // R8: ack in a quiet cycle clears irq
    while (!(m_pcnt == 2 && m_irq[0] == 1)) @(negedge clk);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk(irq_o[0] == 1'b0, "R8 ack clears", 0, int'(irq_o[0]), 0);
    // mixed traffic across rollovers
    for (int c = 0; c < 6000; c++) begin
      r = $urandom;
      idx_wr  = (r[2:0] == 3'd0);
      wdata   = idx_wr ? {4'h0, r[19:16]} : r[27:20];
      data_rd = (r[5:3] < 3'd3);
      data_wr = (r[11:6] == 6'd0);
      irq_ack = (r[14:12] == 3'd0);
      @(negedge clk);
    end
    idx_wr = 0; data_rd = 0; data_wr = 0; irq_ack = 0;
    // R5: final calendar state on the rollover instances
    read_at(8'h07);
    chk(int'(rd_o[1]) == t_dom[1], "R5 leap day", 1, int'(rd_o[1]), t_dom[1]);
    read_at(8'h08);
    chk(rd_o[2] == 8'd3, "R5 common Feb to Mar", 2, int'(rd_o[2]), 3);
    read_at(8'h09);
    chk(rd_o[3] == 8'd56, "R5 year carry", 3, int'(rd_o[3]), 56);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule